// File: doc/BRIEF.md
# Flash Completion Polling Sequencer

This block sits on the host side of a byte-wide parallel flash that guards every write with a software protection sequence. A request names an operation (byte program, sector erase, block erase or chip erase), a target address and, for a program, a data byte. The block emits the unlock and command bus writes the device expects, one strobe per cycle. It then reads the device status repeatedly until the internal operation has finished.

Two completion tests are available, chosen per request. Data polling compares status bit 7 against the expected final value. Toggle detection waits for bit 6 to stop alternating between two back-to-back reads. Once completion is seen, the block waits a parameterised settle time and then reads the full byte. It returns that byte with a one-cycle `done`. If completion does not arrive within the time limit for the operation type, or a programmed byte reads back wrong, it raises a one-cycle `err` with a code instead.

Top module: `flash_poll_seq`

## Requirements
- R1: A program request (req_op = 0) produces exactly four write strobes before the first read: (UNLOCK_ADDR_A, 0xAA), (UNLOCK_ADDR_B, 0x55), (UNLOCK_ADDR_A, 0xA0), then (req_addr, req_data).
- R2: An erase request produces exactly six write strobes before the first read: (A, 0xAA), (B, 0x55), (A, 0x80), (A, 0xAA), (B, 0x55), then a final write. The final write is (req_addr, 0x30) for req_op = 1 (sector), (req_addr, 0x50) for req_op = 2 (block), or (UNLOCK_ADDR_A, 0x10) for req_op = 3 (chip).
- R3: No read strobe occurs before the last command write strobe of a request. No write strobe occurs once status reads have begun. bus_wr and bus_rd are never high together.
- R4: With req_toggle = 0, a program is complete when status bit 7 equals bit 7 of req_data, and an erase is complete when status bit 7 reads 1.
- R5: With req_toggle = 1, an operation is complete when two consecutive status reads return the same bit 6.
- R6: The verify read strobe goes to req_addr exactly SETTLE_CYCLES+2 cycles after the status read strobe that showed completion. The byte it returns appears on rd_data while done is high.
- R7: If completion is not seen, err pulses with err_code = 1. The pulse comes between L and L+5 cycles after the last write strobe, where L is PROG_TMO_CYCLES for a program and ERASE_TMO_CYCLES for an erase.
- R8: req_ready is high only while the block is idle. A request is taken on req_valid && req_ready, and req_ready is low in the following cycle. No bus strobe is driven while req_ready is high.
- R9: done and err are single-cycle pulses and are never high together.
- R10: For a program, a verify byte that differs from req_data gives err with err_code = 2, with the byte read on rd_data.
- R11: After reset, req_ready is 1 and bus_wr, bus_rd, done and err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | ADDR_W | Target byte, sector or block address |
| req_data | input | DATA_W | Byte to program |
| req_toggle | input | 1 | 1 selects bit-6 toggle detection, 0 selects bit-7 data polling |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid the cycle after bus_rd |
| done | output | 1 | Operation finished, rd_data valid |
| err | output | 1 | Operation failed, err_code valid |
| err_code | output | 2 | 1 timeout, 2 verify mismatch |
| rd_data | output | DATA_W | Verify-read byte |

## Verification
The assertions assume that a request is only offered while req_ready is high, that req_op stays stable for the cycle in which it is taken, and that bus_rdata answers each read one cycle later. The bench issues each request at a falling edge, holds it for one rising edge while the block is idle, and waits for the result before it offers the next. A behavioural flash model registers its read data on the rising edge after bus_rd. The model reports busy, stuck or corrupt behaviour only through the status bits and stored bytes, so every outcome the bench sees comes from what the block decided from those bytes.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_SECT = 2'd1,
      OP_BLK  = 2'd2,
      OP_CHIP = 2'd3
   } fop_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_WR,
      S_POLL,
      S_EVAL,
      S_SETTLE,
      S_VRD,
      S_VEVAL
   } fst_e;

   typedef enum logic [1:0] {
      ERR_NONE     = 2'd0,
      ERR_TIMEOUT  = 2'd1,
      ERR_MISMATCH = 2'd2
   } ferr_e;

   localparam logic [7:0] CMD_KEY1  = 8'hAA;
   localparam logic [7:0] CMD_KEY2  = 8'h55;
   localparam logic [7:0] CMD_PROG  = 8'hA0;
   localparam logic [7:0] CMD_ERASE = 8'h80;
   localparam logic [7:0] CMD_SECT  = 8'h30;
   localparam logic [7:0] CMD_BLK   = 8'h50;
   localparam logic [7:0] CMD_CHIP  = 8'h10;

endpackage

// File: rtl/fps_cmd_seq.sv
module fps_cmd_seq
   import flash_poll_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] KEY_ADDR_A = ADDR_W'('h5555),
   parameter logic [ADDR_W-1:0] KEY_ADDR_B = ADDR_W'('h2AAA)
) (
   input  fop_e              op,
   input  logic [2:0]        idx,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic [DATA_W-1:0] tgt_data,
   output logic [ADDR_W-1:0] cyc_addr,
   output logic [DATA_W-1:0] cyc_data,
   output logic              cyc_last
);

   localparam int PROG_LAST  = 3;
   localparam int ERASE_LAST = 5;

   always_comb begin
      cyc_addr = KEY_ADDR_A;
      cyc_data = DATA_W'(CMD_KEY1);
      cyc_last = 1'b0;
      if (op == OP_PROG) begin
         case (idx)
            3'd0: begin cyc_addr = KEY_ADDR_A; cyc_data = DATA_W'(CMD_KEY1); end
            3'd1: begin cyc_addr = KEY_ADDR_B; cyc_data = DATA_W'(CMD_KEY2); end
            3'd2: begin cyc_addr = KEY_ADDR_A; cyc_data = DATA_W'(CMD_PROG); end
            default: begin
               cyc_addr = tgt_addr;
               cyc_data = tgt_data;
               cyc_last = (idx >= 3'(PROG_LAST));
            end
         endcase
      end else begin
         case (idx)
            3'd0: begin cyc_addr = KEY_ADDR_A; cyc_data = DATA_W'(CMD_KEY1);  end
            3'd1: begin cyc_addr = KEY_ADDR_B; cyc_data = DATA_W'(CMD_KEY2);  end
            3'd2: begin cyc_addr = KEY_ADDR_A; cyc_data = DATA_W'(CMD_ERASE); end
            3'd3: begin cyc_addr = KEY_ADDR_A; cyc_data = DATA_W'(CMD_KEY1);  end
            3'd4: begin cyc_addr = KEY_ADDR_B; cyc_data = DATA_W'(CMD_KEY2);  end
            default: begin
               cyc_last = (idx >= 3'(ERASE_LAST));
               case (op)
                  OP_SECT: begin cyc_addr = tgt_addr;   cyc_data = DATA_W'(CMD_SECT); end
                  OP_BLK:  begin cyc_addr = tgt_addr;   cyc_data = DATA_W'(CMD_BLK);  end
                  default: begin cyc_addr = KEY_ADDR_A; cyc_data = DATA_W'(CMD_CHIP); end
               endcase
            end
         endcase
      end
   end

endmodule

// File: rtl/fps_status_eval.sv
module fps_status_eval (
   input  logic use_toggle,
   input  logic is_prog,
   input  logic exp_bit7,
   input  logic rd_bit7,
   input  logic rd_bit6,
   input  logic prev_bit6,
   input  logic have_prev,
   output logic complete
);

   logic poll_ok;
   logic toggle_ok;

   // Data polling: program waits for true bit 7, erase waits for a 1.
   assign poll_ok   = is_prog ? (rd_bit7 == exp_bit7) : rd_bit7;
   // Toggle: bit 6 stops alternating once the internal operation ends.
   assign toggle_ok = have_prev && (rd_bit6 == prev_bit6);
   assign complete  = use_toggle ? toggle_ok : poll_ok;

endmodule

// File: rtl/fps_timer.sv
module fps_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load)                cnt_q <= load_val;
      else if (dec && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/flash_poll_seq.sv
module flash_poll_seq
   import flash_poll_pkg::*;
#(
   parameter int ADDR_W           = 19,
   parameter int DATA_W           = 8,
   parameter int SETTLE_CYCLES    = 50,
   parameter int PROG_TMO_CYCLES  = 5000,
   parameter int ERASE_TMO_CYCLES = 100000,
   parameter bit VERIFY_PROG      = 1'b1,
   parameter logic [ADDR_W-1:0] UNLOCK_ADDR_A = ADDR_W'('h5555),
   parameter logic [ADDR_W-1:0] UNLOCK_ADDR_B = ADDR_W'('h2AAA)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_toggle,
   output logic              bus_wr,
   output logic              bus_rd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              done,
   output logic              err,
   output logic [1:0]        err_code,
   output logic [DATA_W-1:0] rd_data
);

   localparam int TMO_MAX = (PROG_TMO_CYCLES > ERASE_TMO_CYCLES) ? PROG_TMO_CYCLES : ERASE_TMO_CYCLES;
   localparam int TMO_W   = $clog2(TMO_MAX + 1);
   localparam int SET_W   = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;

   generate
      if (DATA_W < 8) begin : g_chk_dw
         $error("DATA_W must be at least 8");
      end
      if (ADDR_W < 2) begin : g_chk_aw
         $error("ADDR_W too small");
      end
      if (SETTLE_CYCLES < 1) begin : g_chk_set
         $error("SETTLE_CYCLES must be at least 1");
      end
      if (PROG_TMO_CYCLES < 2 || ERASE_TMO_CYCLES < 2) begin : g_chk_tmo
         $error("timeout limits must be at least 2");
      end
   endgenerate

   fst_e              st_q;
   fop_e              op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              tgl_q;
   logic [2:0]        idx_q;
   logic              prev6_q;
   logic              havep_q;
   logic              done_q;
   logic              err_q;
   ferr_e             code_q;
   logic [DATA_W-1:0] rd_q;

   logic [ADDR_W-1:0] seq_addr;
   logic [DATA_W-1:0] seq_data;
   logic              seq_last;
   logic              complete;
   logic              mismatch;
   logic              is_prog;
   logic              tmo_zero;
   logic              set_zero;
   logic              tmo_load;
   logic              set_load;
   logic [TMO_W-1:0]  tmo_val;

   assign is_prog = (op_q == OP_PROG);

   fps_cmd_seq #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .KEY_ADDR_A (UNLOCK_ADDR_A),
      .KEY_ADDR_B (UNLOCK_ADDR_B)
   ) i_cmd_seq (
      .op       (op_q),
      .idx      (idx_q),
      .tgt_addr (addr_q),
      .tgt_data (data_q),
      .cyc_addr (seq_addr),
      .cyc_data (seq_data),
      .cyc_last (seq_last)
   );

   fps_status_eval i_status (
      .use_toggle (tgl_q),
      .is_prog    (is_prog),
      .exp_bit7   (data_q[7]),
      .rd_bit7    (bus_rdata[7]),
      .rd_bit6    (bus_rdata[6]),
      .prev_bit6  (prev6_q),
      .have_prev  (havep_q),
      .complete   (complete)
   );

   assign tmo_load = (st_q == S_WR) && seq_last;
   assign tmo_val  = is_prog ? TMO_W'(PROG_TMO_CYCLES) : TMO_W'(ERASE_TMO_CYCLES);

   fps_timer #(.W(TMO_W)) i_tmo (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmo_load),
      .load_val (tmo_val),
      .dec      ((st_q == S_POLL) || (st_q == S_EVAL)),
      .zero     (tmo_zero)
   );

   assign set_load = (st_q == S_EVAL) && complete;

   fps_timer #(.W(SET_W)) i_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (set_load),
      .load_val (SET_W'(SETTLE_CYCLES - 1)),
      .dec      (st_q == S_SETTLE),
      .zero     (set_zero)
   );

   generate
      if (VERIFY_PROG) begin : g_verify
         assign mismatch = is_prog && (bus_rdata != data_q);
      end else begin : g_noverify
         assign mismatch = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         op_q    <= OP_PROG;
         addr_q  <= '0;
         data_q  <= '0;
         tgl_q   <= 1'b0;
         idx_q   <= '0;
         prev6_q <= 1'b0;
         havep_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         code_q  <= ERR_NONE;
         rd_q    <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (req_valid) begin
                  op_q   <= fop_e'(req_op);
                  addr_q <= req_addr;
                  data_q <= req_data;
                  tgl_q  <= req_toggle;
                  idx_q  <= '0;
                  st_q   <= S_WR;
               end
            end
            S_WR: begin
               if (seq_last) begin
                  havep_q <= 1'b0;
                  st_q    <= S_POLL;
               end else begin
                  idx_q <= idx_q + 3'd1;
               end
            end
            S_POLL: st_q <= S_EVAL;
            S_EVAL: begin
               if (complete) begin
                  st_q <= S_SETTLE;
               end else if (tmo_zero) begin
                  err_q  <= 1'b1;
                  code_q <= ERR_TIMEOUT;
                  st_q   <= S_IDLE;
               end else begin
                  prev6_q <= bus_rdata[6];
                  havep_q <= 1'b1;
                  st_q    <= S_POLL;
               end
            end
            S_SETTLE: if (set_zero) st_q <= S_VRD;
            S_VRD:    st_q <= S_VEVAL;
            S_VEVAL: begin
               rd_q <= bus_rdata;
               if (mismatch) begin
                  err_q  <= 1'b1;
                  code_q <= ERR_MISMATCH;
               end else begin
                  done_q <= 1'b1;
               end
               st_q <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready = (st_q == S_IDLE);
   assign bus_wr    = (st_q == S_WR);
   assign bus_rd    = (st_q == S_POLL) || (st_q == S_VRD);
   assign bus_addr  = (st_q == S_WR) ? seq_addr : addr_q;
   assign bus_wdata = (st_q == S_WR) ? seq_data : '0;
   assign done      = done_q;
   assign err       = err_q;
   assign err_code  = code_q;
   assign rd_data   = rd_q;

endmodule

// File: rtl/fps_checker.sv
module fps_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic [1:0] req_op,
   input logic       bus_wr,
   input logic       bus_rd,
   input logic       done,
   input logic       err,
   input logic [1:0] err_code
);

   logic [2:0] wr_cnt_q;
   logic       prog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_cnt_q <= '0;
         prog_q   <= 1'b1;
      end else if (req_valid && req_ready) begin
         wr_cnt_q <= '0;
         prog_q   <= (req_op == 2'd0);
      end else if (bus_wr) begin
         wr_cnt_q <= wr_cnt_q + 3'd1;
      end
   end

   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd)); // R3
   AST_RD_AFTER_LAST_WR: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> (wr_cnt_q == (prog_q ? 3'd4 : 3'd6))); // R3
   AST_WR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> (wr_cnt_q < (prog_q ? 3'd4 : 3'd6))); // R1
   AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!bus_wr && !bus_rd)); // R8
   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err)); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err); // R9
   AST_ERR_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (err_code == 2'd1 || err_code == 2'd2)); // R7

endmodule

bind flash_poll_seq fps_checker i_fps_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_op    (req_op),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .done      (done),
   .err       (err),
   .err_code  (err_code)
);

// File: tb/test_flash_poll_seq.sv
module test_flash_poll_seq;

   localparam int AW  = 19;
   localparam int DW  = 8;
   localparam int SET = 20;
   localparam int PT  = 300;
   localparam int ET  = 600;
   localparam logic [AW-1:0] UA = 19'h05555;
   localparam logic [AW-1:0] UB = 19'h02AAA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          req_toggle = 1'b0;
   logic          bus_wr, bus_rd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata = '0;
   logic          done, err;
   logic [1:0]    err_code;
   logic [DW-1:0] rd_data;

   always #10 clk = ~clk;

   flash_poll_seq #(
      .ADDR_W(AW), .DATA_W(DW), .SETTLE_CYCLES(SET),
      .PROG_TMO_CYCLES(PT), .ERASE_TMO_CYCLES(ET)
   ) i_flash_poll_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_toggle(req_toggle),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .done(done), .err(err), .err_code(err_code), .rd_data(rd_data)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural flash model ----------------
   logic [7:0] mem [256];
   int  seq = 0, busy = 0, busy_len = 5;
   bit  stuck = 0, corrupt = 0, tog = 0, er = 0;
   logic [7:0] pd = '0;

   initial for (int i = 0; i < 256; i++) mem[i] = 8'hFF;

   always @(posedge clk) begin
      if (bus_wr) begin
         case (seq)
            0: seq = (bus_addr == UA && bus_wdata == 8'hAA) ? 1 : 0;
            1: seq = (bus_addr == UB && bus_wdata == 8'h55) ? 2 : 0;
            2: seq = (bus_addr == UA && bus_wdata == 8'hA0) ? 10 :
                     (bus_addr == UA && bus_wdata == 8'h80) ? 3 : 0;
            3: seq = (bus_addr == UA && bus_wdata == 8'hAA) ? 4 : 0;
            4: seq = (bus_addr == UB && bus_wdata == 8'h55) ? 5 : 0;
            5: begin
               if (bus_wdata == 8'h30 || bus_wdata == 8'h50 ||
                   (bus_wdata == 8'h10 && bus_addr == UA)) begin
                  for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
                  busy = busy_len; er = 1;
               end
               seq = 0;
            end
            10: begin
               mem[bus_addr[7:0]] = corrupt ? (bus_wdata ^ 8'h01) : bus_wdata;
               pd = bus_wdata; busy = busy_len; er = 0; seq = 0;
            end
            default: seq = 0;
         endcase
      end
      if (bus_rd) begin
         if (busy > 0 || stuck) begin
            tog = ~tog;
            bus_rdata <= er ? {1'b0, tog, 6'h00} : {~pd[7], tog, pd[5:0]};
            if (!stuck) busy--;
         end else begin
            bus_rdata <= mem[bus_addr[7:0]];
         end
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct { bit is_err; bit [1:0] code; bit [7:0] data; } exp_t;
   exp_t q[$];

   int cyc = 0;
   always @(posedge clk) cyc++;

   int wr_cnt = 0, exp_wr = 4, last_wr_cyc = 0, prev_rd = 0, last_rd = 0, exp_tmo = 0;
   bit polling = 0, pulse_prev = 0;
   logic [AW-1:0] last_wr_a, exp_last_a;
   logic [7:0]    last_wr_d, exp_last_d;

   always @(negedge clk) begin
      if (rst_n) begin
         if (pulse_prev) chk(!(done || err), "R9", "pulse longer than one cycle", done | err, 0);
         pulse_prev = done || err;
         if (bus_wr) begin
            if (polling) chk(0, "R3", "write after polling started", 1, 0);
            wr_cnt++; last_wr_a = bus_addr; last_wr_d = bus_wdata; last_wr_cyc = cyc;
         end
         if (bus_rd) begin
            if (!polling) begin
               polling = 1;
               chk(wr_cnt == exp_wr, exp_wr == 4 ? "R1" : "R2", "strobes before read", wr_cnt, exp_wr);
               chk(last_wr_a == exp_last_a, exp_wr == 4 ? "R1" : "R2", "last write addr", last_wr_a, exp_last_a);
               chk(last_wr_d == exp_last_d, exp_wr == 4 ? "R1" : "R2", "last write data", last_wr_d, exp_last_d);
            end
            prev_rd = last_rd; last_rd = cyc;
         end
         if (done || err) begin
            exp_t e;
            chk(!(done && err), "R9", "done and err together", 1, 0);
            if (q.size() == 0) chk(0, "R9", "unexpected result", 1, 0);
            else begin
               e = q.pop_front();
               chk(err == e.is_err, "R9", "result kind", err, e.is_err);
               if (e.is_err) begin
                  chk(err_code == e.code, e.code == 2 ? "R10" : "R7", "err_code", err_code, e.code);
                  if (e.code == 2) chk(rd_data == e.data, "R10", "mismatch byte", rd_data, e.data);
                  if (e.code == 1) chk((cyc - last_wr_cyc) >= exp_tmo && (cyc - last_wr_cyc) <= exp_tmo + 5,
                                       "R7", "timeout delay", cyc - last_wr_cyc, exp_tmo);
               end else begin
                  chk(rd_data == e.data, "R6", "verify data", rd_data, e.data);
                  chk(last_rd - prev_rd == SET + 2, "R6", "settle gap", last_rd - prev_rd, SET + 2);
               end
            end
         end
      end
   end

   task automatic run(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                      input bit tg, input bit e_err, input bit [1:0] e_code, input bit [7:0] e_data);
      exp_t e;
      e.is_err = e_err; e.code = e_code; e.data = e_data;
      @(negedge clk);
      q.push_back(e);
      wr_cnt = 0; polling = 0;
      exp_wr  = (op == 2'd0) ? 4 : 6;
      exp_tmo = (op == 2'd0) ? PT : ET;
      case (op)
         2'd0: begin exp_last_a = a;  exp_last_d = d;     end
         2'd1: begin exp_last_a = a;  exp_last_d = 8'h30; end
         2'd2: begin exp_last_a = a;  exp_last_d = 8'h50; end
         default: begin exp_last_a = UA; exp_last_d = 8'h10; end
      endcase
      chk(req_ready == 1'b1, "R8", "ready before request", req_ready, 1);
      req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_toggle = tg;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R8", "ready after accept", req_ready, 0);
      while (q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(req_ready == 1'b1, "R11", "ready in reset", req_ready, 1);
      chk(!bus_wr && !bus_rd, "R11", "strobes in reset", {bus_wr, bus_rd}, 0);
      chk(!done && !err, "R11", "pulses in reset", {done, err}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1/R4: data polling program, bit 7 clear and set
      run(2'd0, 19'd3, 8'h5A, 0, 0, 0, 8'h5A);
      run(2'd0, 19'd4, 8'hA5, 0, 0, 0, 8'hA5);
      // R5: toggle mode program
      run(2'd0, 19'd5, 8'h3C, 1, 0, 0, 8'h3C);
      // R4/R5: device already finished on the first status read
      busy_len = 0;
      run(2'd0, 19'd6, 8'h81, 1, 0, 0, 8'h81);
      run(2'd0, 19'd7, 8'h7E, 0, 0, 0, 8'h7E);
      busy_len = 6;
      // R2: sector (polling), block (toggle), chip (polling)
      run(2'd1, 19'd3, 8'h00, 0, 0, 0, 8'hFF);
      run(2'd2, 19'd4, 8'h00, 1, 0, 0, 8'hFF);
      run(2'd3, 19'd9, 8'h00, 0, 0, 0, 8'hFF);
      // R10: verify mismatch
      corrupt = 1;
      run(2'd0, 19'd8, 8'hC3, 0, 1, 2'd1 + 2'd1, 8'hC2);
      corrupt = 0;
      // R7: timeouts for program (polling) and erase (toggle)
      stuck = 1;
      run(2'd0, 19'd9, 8'h11, 0, 1, 2'd1, 8'h00);
      run(2'd1, 19'd9, 8'h00, 1, 1, 2'd1, 8'h00);
      stuck = 0;
      // recovery after errors
      run(2'd0, 19'd10, 8'h66, 0, 0, 0, 8'h66);
      finish_run();
   end

endmodule